// File: doc/BRIEF.md
# Two-Step Reciprocal Refinement Datapath

This block turns a coarse reciprocal estimate, good to roughly 14 bits, into a single-precision reciprocal. It uses one Newton-Raphson pass, R = R0 x (2 - b x R0). The pass is split into two short step operations, so no long-latency divider is needed. Each step accepts one operation per cycle and returns its result two cycles later.

Step one takes the operand b and the estimate R0. It returns a packed 24-bit intermediate that stands for 2 - b x R0. Step two takes that intermediate and the same estimate R0, and returns the refined IEEE single-precision reciprocal.

Every 64-bit input word carries two independent 32-bit lanes, and both lanes are processed at once. Software chains the two steps: the step-one result word is fed back as the source operand of step two. Denormals are treated as zero, only round-half-up is used, and no exceptions are raised.

Top module: `nr_recip_refine`

## Requirements
- R1: An operation accepted with `in_valid` high at clock edge k produces `out_valid` high after edge k+2 with its result on `out_res`. One operation can be accepted on every edge. `out_valid` is low whenever no operation was accepted two edges earlier.
- R2: Lane i of a word occupies bits [32i+31:32i]. Each lane of `out_res` depends only on the same lane of `in_src` and `in_est`.
- R3: Step one (`in_op` = 0) multiplies the 24-bit mantissas of b (`in_src`) and R0 (`in_est`), giving a product P in 2.46 fixed point. Call the sum of the two 8-bit exponent fields S. When S equals 254, v = floor((P + 2^14) / 2^15); otherwise v = floor((P + 2^15) / 2^16). Only the low 32 bits of v are kept.
- R4: A step-one lane for a b with a nonzero exponent field is formatted as follows: bit 31 = 0, bit 30 = sign of b, bits 29..24 = 0, bits 23..0 = bitwise inverse of bits 23..0 of v.
- R5: A step-one lane whose b has a zero exponent field (zero or denormal) yields bit 31 = 1, bit 30 = sign of b, and all other bits 0.
- R6: Step two (`in_op` = 1) rebuilds a 32-bit factor y from the 24-bit intermediate q in bits 23..0 of `in_src`. Bit 31 of y is the inverse of q[23], bits 30..24 are copies of q[23], and bits 23..0 are q.
- R7: Step two forms M = mantissa(R0) x y, a 56-bit value. The shift s is 32 if M[55] is set, 31 if M[54] is set, and 30 otherwise; the matching exponent offset is +1, 0 or -1. The block adds 2^(s-1) and shifts right by s. A carry into bit 24 is shifted down once more and adds one more to the exponent. The result is {bit 30 of `in_src`, exponent field of R0 + offset, low 23 mantissa bits}.
- R8: A step-two lane whose intermediate has bit 31 set returns the largest finite magnitude, exponent 0xFE with all fraction bits set, using bit 30 of the intermediate as its sign.
- R9: For b with a normal exponent and R0 equal to 1/b truncated to 14 fraction bits, chaining step one and step two gives a result within one unit in the last place of the exact 1/b.
- R10: While `rst` is high, `out_valid` is low after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| in_op | input | 1 | 0 = step one, 1 = step two |
| in_src | input | 64 | Two lanes: operand b (step one) or intermediate (step two) |
| in_est | input | 64 | Two lanes: reciprocal estimate R0 |
| out_valid | output | 1 | Result present on out_res |
| out_res | output | 64 | Two result lanes |

## Verification
Every result, whether from step one or step two, is due exactly two clock edges after the edge that accepted it. Bubbles and back-to-back issue do not change this. The driver stamps each expected item with the cycle count at which its result must appear, two past the issue count. The monitor samples on the falling edge and pops an item only when the count matches. A missing result on a due cycle, or `out_valid` on a cycle with nothing due, is reported against R1. Chained step-two items also carry the real-valued reciprocal, so the one-ulp bound is checked on the design's own output.

// File: rtl/nr_pkg.sv
package nr_pkg;

    localparam int LANE_W   = 32;
    localparam int MANT_W   = 24;
    localparam int IMM_W    = 24;
    localparam int WIDE_W   = 32;
    localparam int PAD_W    = WIDE_W - MANT_W;
    localparam int PROD_W   = MANT_W + WIDE_W;
    localparam int RND_W    = PROD_W + 1;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;

    localparam logic [EXP_W:0]    EXP_SUM_UNITY = 9'd254;
    localparam logic [EXP_W-1:0]  EXP_SAT       = 8'hFE;

    typedef enum logic {
        OP_STEP1 = 1'b0,
        OP_STEP2 = 1'b1
    } nr_op_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } f32_t;

    typedef struct packed {
        logic             zflag;
        logic             sign;
        logic [5:0]       pad;
        logic [IMM_W-1:0] imm;
    } imm_word_t;

    typedef struct packed {
        nr_op_e            op;
        logic              sign;
        logic              zero;
        logic              half_scale;
        logic [EXP_W-1:0]  rexp;
        logic [PROD_W-1:0] prod;
    } nr_mid_t;

    function automatic logic [MANT_W-1:0] mant_of(f32_t f);
        return {f.exp != '0, f.frac};
    endfunction

    function automatic logic [WIDE_W-1:0] widen_imm(logic [IMM_W-1:0] q);
        return {~q[IMM_W-1], {(WIDE_W-IMM_W-1){q[IMM_W-1]}}, q};
    endfunction

endpackage

// File: rtl/nr_mul_stage.sv
module nr_mul_stage
    import nr_pkg::*;
(
    input  logic                clk,
    input  logic                en,
    input  nr_op_e              op,
    input  logic [LANE_W-1:0]   src_a,
    input  logic [LANE_W-1:0]   src_r,
    output nr_mid_t             mid_q
);

    f32_t              fa;
    f32_t              fr;
    imm_word_t         iw;
    logic [WIDE_W-1:0] mul_a;
    logic [MANT_W-1:0] mul_b;
    nr_mid_t           mid_d;

    always_comb begin
        fa    = f32_t'(src_a);
        fr    = f32_t'(src_r);
        iw    = imm_word_t'(src_a);
        mul_b = mant_of(fr);
        if (op == OP_STEP1) begin
            mul_a = {mant_of(fa), {PAD_W{1'b0}}};
        end else begin
            mul_a = widen_imm(iw.imm);
        end
        mid_d.op         = op;
        mid_d.sign       = (op == OP_STEP1) ? fa.sign : iw.sign;
        mid_d.zero       = (op == OP_STEP1) ? (fa.exp == '0) : iw.zflag;
        mid_d.half_scale = ({1'b0, fa.exp} + {1'b0, fr.exp}) != EXP_SUM_UNITY;
        mid_d.rexp       = fr.exp;
        mid_d.prod       = PROD_W'(mul_a) * PROD_W'(mul_b);
    end

    always_ff @(posedge clk) begin
        if (en) begin
            mid_q <= mid_d;
        end
    end

endmodule

// File: rtl/nr_fin_stage.sv
module nr_fin_stage
    import nr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  nr_mid_t           mid,
    output logic [LANE_W-1:0] res_q
);

    localparam logic [RND_W-1:0] BIAS_UNITY = RND_W'(1) << (PAD_W + 14);
    localparam logic [RND_W-1:0] BIAS_HALF  = RND_W'(1) << (PAD_W + 15);
    localparam logic [RND_W-1:0] BIAS_UP    = RND_W'(1) << 31;
    localparam logic [RND_W-1:0] BIAS_MID   = RND_W'(1) << 30;
    localparam logic [RND_W-1:0] BIAS_DN    = RND_W'(1) << 29;

    logic [RND_W-1:0]  s1_sum;
    logic [WIDE_W-1:0] s1_v;
    imm_word_t         s1_word;

    logic [RND_W-1:0]  s2_sum;
    logic [MANT_W:0]   s2_m;
    logic [MANT_W-1:0] s2_mant;
    logic [EXP_W-1:0]  s2_adj;
    f32_t              s2_word;

    logic [LANE_W-1:0] res_d;

    // Step one: round the product to 32 bits, invert, keep the low 24 bits
    always_comb begin
        s1_sum = {1'b0, mid.prod} + (mid.half_scale ? BIAS_HALF : BIAS_UNITY);
        s1_v   = mid.half_scale ? s1_sum[PROD_W-1 -: WIDE_W]
                                : s1_sum[PROD_W-2 -: WIDE_W];
        s1_word.zflag = mid.zero;
        s1_word.sign  = mid.sign;
        s1_word.pad   = '0;
        s1_word.imm   = mid.zero ? '0 : ~s1_v[IMM_W-1:0];
    end

    // Step two: normalise, add the rounding bias, renormalise on carry
    always_comb begin
        if (mid.prod[PROD_W-1]) begin
            s2_sum = {1'b0, mid.prod} + BIAS_UP;
            s2_m   = s2_sum[RND_W-1 -: MANT_W+1];
            s2_adj = 8'd1;
        end else if (mid.prod[PROD_W-2]) begin
            s2_sum = {1'b0, mid.prod} + BIAS_MID;
            s2_m   = s2_sum[RND_W-2 -: MANT_W+1];
            s2_adj = 8'd0;
        end else begin
            s2_sum = {1'b0, mid.prod} + BIAS_DN;
            s2_m   = s2_sum[RND_W-3 -: MANT_W+1];
            s2_adj = 8'hFF;
        end
        if (s2_m[MANT_W]) begin
            s2_mant = s2_m[MANT_W:1];
            s2_adj  = s2_adj + 8'd1;
        end else begin
            s2_mant = s2_m[MANT_W-1:0];
        end
        s2_word.sign = mid.sign;
        if (mid.zero) begin
            s2_word.exp  = EXP_SAT;
            s2_word.frac = '1;
        end else begin
            s2_word.exp  = mid.rexp + s2_adj;
            s2_word.frac = s2_mant[FRAC_W-1:0];
        end
    end

    assign res_d = (mid.op == OP_STEP1) ? LANE_W'(s1_word) : LANE_W'(s2_word);

    always_ff @(posedge clk) begin
        if (en) begin
            res_q <= res_d;
        end
    end

    // R4: a nonzero step-one lane leaves its flag and pad bits clear
    p_step1_fmt_r4: assert property (@(posedge clk) disable iff (rst)
        (en && mid.op == OP_STEP1 && !mid.zero) |=>
            (res_q[31] == 1'b0 && res_q[29:24] == 6'd0));

    // R5: a zero step-one operand raises the flag and carries its sign
    p_step1_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (en && mid.op == OP_STEP1 && mid.zero) |=>
            (res_q == {1'b1, $past(mid.sign), 30'd0}));

    // R8: a flagged intermediate yields the saturated magnitude
    p_step2_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (en && mid.op == OP_STEP2 && mid.zero) |=>
            (res_q[30:0] == {EXP_SAT, {FRAC_W{1'b1}}}));

    // R7: the result exponent moves by -1 .. +2 from the estimate exponent
    p_step2_exp_r7: assert property (@(posedge clk) disable iff (rst)
        (en && mid.op == OP_STEP2 && !mid.zero) |=>
            ((8'(res_q[30:23] - $past(mid.rexp)) == 8'hFF) ||
             (8'(res_q[30:23] - $past(mid.rexp)) <= 8'd2)));

endmodule

// File: rtl/nr_recip_refine.sv
module nr_recip_refine
    import nr_pkg::*;
#(
    parameter int LANES = 2,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [BUS_W-1:0] in_src,
    input  logic [BUS_W-1:0] in_est,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_res
);

    logic   v_s1;
    nr_op_e op_in;

    assign op_in = nr_op_e'(in_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            v_s1      <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v_s1      <= in_valid;
            out_valid <= v_s1;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        nr_mid_t           mid_q;
        logic [LANE_W-1:0] res_q;

        nr_mul_stage u_mul (
            .clk   (clk),
            .en    (in_valid),
            .op    (op_in),
            .src_a (in_src[g*LANE_W +: LANE_W]),
            .src_r (in_est[g*LANE_W +: LANE_W]),
            .mid_q (mid_q)
        );

        nr_fin_stage u_fin (
            .clk   (clk),
            .rst   (rst),
            .en    (v_s1),
            .mid   (mid_q),
            .res_q (res_q)
        );

        assign out_res[g*LANE_W +: LANE_W] = res_q;
    end

    // R1: an accepted operation moves into the middle stage
    p_issue_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> v_s1);

    // R1: the middle stage always drains to the output one edge later
    p_drain_r1: assert property (@(posedge clk) disable iff (rst)
        v_s1 |=> out_valid);

    // R1: no result appears without an operation two edges earlier
    p_no_spur_r1: assert property (@(posedge clk) disable iff (rst)
        !v_s1 |=> !out_valid);

    // R10: reset clears the output flag
    p_reset_r10: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/sim_nr_recip_refine.sv
module sim_nr_recip_refine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [63:0] in_src = '0;
    logic [63:0] in_est = '0;
    logic        out_valid;
    logic [63:0] out_res;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    typedef struct {
        int          due;
        logic [63:0] exp;
        bit          acc;
        real         inv0;
        real         inv1;
        string       tag;
    } item_t;

    item_t sbq[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    nr_recip_refine u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_src(in_src), .in_est(in_est), .out_valid(out_valid), .out_res(out_res)
    );

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    function automatic real f2r(logic [31:0] w);
        real m;
        int  e;
        if (w[30:23] == 8'd0) return 0.0;
        m = 1.0 + real'(w[22:0]) / 8388608.0;
        e = int'(w[30:23]) - 127;
        if (e >= 0) repeat (e) m = m * 2.0;
        else repeat (-e) m = m * 0.5;
        return w[31] ? -m : m;
    endfunction

    function automatic real ulp_of(logic [31:0] w);
        real u = 1.0;
        int  e = int'(w[30:23]) - 150;
        if (e >= 0) repeat (e) u = u * 2.0;
        else repeat (-e) u = u * 0.5;
        return u;
    endfunction

    // R3, R4, R5 expected step-one lane
    function automatic logic [31:0] m_step1(logic [31:0] a, logic [31:0] r);
        logic [63:0] mb, mr, p, v;
        logic [8:0]  s;
        logic [31:0] v32;
        if (a[30:23] == 8'd0) return {1'b1, a[31], 30'd0};
        mb = {40'd0, 1'b1, a[22:0]};
        mr = {40'd0, r[30:23] != 8'd0, r[22:0]};
        p  = mb * mr;
        s  = {1'b0, a[30:23]} + {1'b0, r[30:23]};
        if (s == 9'd254) v = (p + 64'd16384) >> 15;
        else v = (p + 64'd32768) >> 16;
        v32 = v[31:0];
        return {1'b0, a[31], 6'd0, ~v32[23:0]};
    endfunction

    // R6, R7, R8 expected step-two lane
    function automatic logic [31:0] m_step2(logic [31:0] a, logic [31:0] r);
        logic [23:0] q;
        logic [63:0] y, mr, m, mm;
        int          sh, adj;
        logic [7:0]  e;
        if (a[31]) return {a[30], 8'hFE, 23'h7FFFFF};
        q  = a[23:0];
        y  = {32'd0, ~q[23], {7{q[23]}}, q};
        mr = {40'd0, r[30:23] != 8'd0, r[22:0]};
        m  = mr * y;
        if (m[55]) begin sh = 32; adj = 1; end
        else if (m[54]) begin sh = 31; adj = 0; end
        else begin sh = 30; adj = -1; end
        mm = (m + (64'd1 << (sh - 1))) >> sh;
        if (mm[24]) begin mm = mm >> 1; adj = adj + 1; end
        e = r[30:23] + 8'(adj);
        return {a[30], e, mm[22:0]};
    endfunction

    // estimate: 1/b truncated to 14 fraction bits
    function automatic logic [31:0] est(logic [31:0] b);
        logic [63:0] mb, mr;
        if (b[22:0] == 23'd0) return {b[31], 8'(9'd254 - {1'b0, b[30:23]}), 23'd0};
        mb = {40'd0, 1'b1, b[22:0]};
        mr = (64'd1 << 47) / mb;
        mr = mr & ~64'h1FF;
        return {b[31], 8'(9'd253 - {1'b0, b[30:23]}), mr[22:0]};
    endfunction

    task automatic issue(bit op, logic [63:0] a, logic [63:0] r, bit acc,
                         real i0, real i1, string tag);
        item_t it;
        in_valid = 1'b1;
        in_op    = op;
        in_src   = a;
        in_est   = r;
        it.due   = cyc + 2;
        it.exp[31:0]  = op ? m_step2(a[31:0], r[31:0])   : m_step1(a[31:0], r[31:0]);
        it.exp[63:32] = op ? m_step2(a[63:32], r[63:32]) : m_step1(a[63:32], r[63:32]);
        it.acc  = acc;
        it.inv0 = i0;
        it.inv1 = i1;
        it.tag  = tag;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sbq.size() > 0 && sbq[0].due == cyc) begin
                item_t it;
                it = sbq.pop_front();
                chk(out_valid === 1'b1, "R1 result due", {63'd0, out_valid}, 64'd1);
                chk(out_res[31:0] === it.exp[31:0], {it.tag, " lane0 R2"},
                    {32'd0, out_res[31:0]}, {32'd0, it.exp[31:0]});
                chk(out_res[63:32] === it.exp[63:32], {it.tag, " lane1 R2"},
                    {32'd0, out_res[63:32]}, {32'd0, it.exp[63:32]});
                if (it.acc) begin
                    real d0, d1;
                    d0 = f2r(out_res[31:0]) - it.inv0;
                    d1 = f2r(out_res[63:32]) - it.inv1;
                    if (d0 < 0.0) d0 = -d0;
                    if (d1 < 0.0) d1 = -d1;
                    chk(d0 <= ulp_of(out_res[31:0]), "R9 lane0 ulp",
                        {32'd0, out_res[31:0]}, {32'd0, it.exp[31:0]});
                    chk(d1 <= ulp_of(out_res[63:32]), "R9 lane1 ulp",
                        {32'd0, out_res[63:32]}, {32'd0, it.exp[63:32]});
                end
            end else if (out_valid !== 1'b0) begin
                chk(1'b0, "R1 spurious out_valid", {63'd0, out_valid}, 64'd0);
            end
        end
    end

    // watchdog
    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] b0, b1, r0, r1, s0, s1;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 reset out_valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R3 unity-scale path: b = 1.0, R0 = 1.0 gives low 24 bits all ones
        chk(m_step1(32'h3F800000, 32'h3F800000) == 32'h00FFFFFF, "R3 model unity",
            {32'd0, m_step1(32'h3F800000, 32'h3F800000)}, 64'h00FFFFFF);
        issue(1'b0, {32'h40400000, 32'h3F800000}, {est(32'h40400000), 32'h3F800000},
              0, 0.0, 0.0, "R3 step1 b=3,b=1");

        // R5 zero operands with both signs, next to a normal lane (R2)
        issue(1'b0, {32'h80000000, 32'hBF400000}, {32'h3F800000, est(32'hBF400000)},
              0, 0.0, 0.0, "R5 step1 -0 / -0.75");
        issue(1'b0, {32'h00000000, 32'h00000000}, {32'h3F800000, 32'h3F800000},
              0, 0.0, 0.0, "R5 step1 +0 both lanes");

        // R8 flagged intermediates, positive and negative
        issue(1'b1, {32'hC0000000, 32'h80000000}, {32'h3F800000, 32'h3F800000},
              0, 0.0, 0.0, "R8 step2 saturate");

        // R7 rounding carry into bit 24: mantissa 0xFFFFFE times 1 + 193*2^-31
        issue(1'b1, {32'h000000C1, 32'h000000C1}, {32'h3FFFFFFE, 32'h3F7FFFFF},
              0, 0.0, 0.0, "R7 step2 round carry");
        chk(m_step2(32'h000000C1, 32'h3FFFFFFE) == 32'h40000000, "R7 model carry",
            {32'd0, m_step2(32'h000000C1, 32'h3FFFFFFE)}, 64'h40000000);

        // R6 intermediate with bit 23 set (factor below one) and clear
        issue(1'b1, {32'h00FFF000, 32'h00001000}, {32'h3F800000, 32'h3FC00000},
              0, 0.0, 0.0, "R6 step2 expand");

        idle(3);
        chk(out_valid === 1'b0, "R1 idle after drain", {63'd0, out_valid}, 64'd0);

        // R9 chained directed: b = 3.0 and b = -0.75
        b0 = 32'h40400000; b1 = 32'hBF400000;
        r0 = est(b0); r1 = est(b1);
        s0 = m_step1(b0, r0); s1 = m_step1(b1, r1);
        issue(1'b1, {s1, s0}, {r1, r0}, 1, 1.0 / f2r(b0), 1.0 / f2r(b1), "R9 chain directed");
        idle(1);

        // R9 random chains, back-to-back, with occasional bubbles (R1)
        for (int i = 0; i < 300; i++) begin
            b0 = {1'($urandom), 8'(100 + $urandom_range(0, 50)), 23'($urandom)};
            b1 = {1'($urandom), 8'(100 + $urandom_range(0, 50)), 23'($urandom)};
            if (i % 37 == 0) b1[22:0] = 23'd0;
            r0 = est(b0); r1 = est(b1);
            issue(1'b0, {b1, b0}, {r1, r0}, 0, 0.0, 0.0, "R3 R4 step1 random");
            s0 = m_step1(b0, r0); s1 = m_step1(b1, r1);
            issue(1'b1, {s1, s0}, {r1, r0}, 1, 1.0 / f2r(b0), 1.0 / f2r(b1), "R7 step2 random");
            if (i % 11 == 0) idle(1 + (i % 3));
        end

        idle(6);
        chk(sbq.size() == 0, "R1 scoreboard drained", 64'(sbq.size()), 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule